// File: doc/BRIEF.md
# Chained Watchpoint and Match Counter Unit

This block turns a vector of per-comparator hit flags, one external hit line and two match counters into a vector of eleven watchpoints, and it raises a breakpoint request when a selected watchpoint newly fires. Each watchpoint has its own term. The eight low watchpoints take one comparator hit each. The two next ones take "counter equals its match value". The top one takes the external hit. A 2-bit chain mode per watchpoint combines that term with the result of the watchpoint just below it, so the watchpoints form a cascade that is resolved from the bottom up within one evaluation.

Evaluation happens only on a strobe. On that strobe the unit compares the new results with the stored vector. Each watchpoint that goes from false to true may advance one of the two counters and may request a breakpoint. The counters then feed back into the upper watchpoints on later strobes. Software configures the unit through a small word-wide register port with four addresses. The same port reads the configuration and counter values back.

Top module: `wp_chain_unit`

## Requirements
- R1: After reset, the watchpoint vector, the breakpoint request and all four registers read back as zero.
- R2: The chain mode of watchpoint i sits in bits [2i+1:2i] of register 0. Mode 0 gives the watchpoint's own term. Mode 1 gives own AND the chained input. Mode 2 gives own OR the chained input. Mode 3 gives false.
- R3: Watchpoint 0 takes comparator hit 0 as its own term and has no lower neighbour, so modes 0, 1 and 2 all give hit 0.
- R4: Watchpoints 1 to 7 take comparator hit i as their own term. Their chained input is the result of watchpoint i-1 computed in the same strobe, so a chain cascades through all its links in one evaluation.
- R5: Watchpoint 8's own term is "counter 0 equals match 0" and watchpoint 9's is "counter 1 equals match 1", both using the counter values held before the strobe. Watchpoint 10's own term is the external hit.
- R6: The watchpoint vector output changes only on a cycle with the evaluate strobe, one clock after that strobe. Without a strobe it holds even when the inputs change.
- R7: Register 1 bits [10:0] assign each watchpoint to counter 0 (bit clear) or counter 1 (bit set). Bit 22 enables counter 0 and bit 23 enables counter 1. On a strobe, an enabled counter advances by the number of watchpoints assigned to it that rise from false to true, and it wraps modulo 2^16. A watchpoint that stays true does not count.
- R8: Register 1 bits [21:11] are breakpoint-generate bits, with bit 11+i for watchpoint i. The breakpoint request is high for exactly the one clock after a strobe in which at least one watchpoint with its bit set rose from false to true. A watchpoint that stays true raises no request.
- R9: Registers 2 and 3 hold counter 0 and counter 1 in bits [15:0] and their match values in bits [31:16]. A write to them takes effect one clock later and wins over an increment in the same cycle.
- R10: The read-data output shows the register at the current address combinationally, with unused bits zero. A configuration write takes effect for strobes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe |
| hit_i | input | 8 | Comparator hit flags, bit i for watchpoint i |
| ext_hit_i | input | 1 | External hit, own term of watchpoint 10 |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address (0 modes, 1 assign/generate/enable, 2 counter 0, 3 counter 1) |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data for the addressed register |
| wp_o | output | 11 | Stored watchpoint vector |
| brk_o | output | 1 | Breakpoint request pulse |

## Verification
The bench targets a chain whose middle link is forced false or mode 3. A unit that used the previous strobe's lower results would let the old value through the cascade. It also drives several watchpoints rising on the same counter in one strobe, and a design that counted only once would fall behind. Other cases are a watchpoint held true over successive strobes, where a level-sensitive design would keep counting and requesting breakpoints, and a counter write colliding with an increment, where the wrong priority leaves the counter off by the increment. The counter-equals terms are checked against the value before the strobe's own increment, along with wrap from 0xFFFF, so an off-by-one-cycle equality shows up as a misplaced watchpoint 8 or 9.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;

    typedef enum logic [1:0] {
        CH_SOLO = 2'd0,
        CH_AND  = 2'd1,
        CH_OR   = 2'd2,
        CH_OFF  = 2'd3
    } chain_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_CNT0 = 2'd2;
    localparam logic [1:0] ADDR_CNT1 = 2'd3;

endpackage

// File: rtl/wpc_cell.sv
`timescale 1ns/1ps
module wpc_cell
    import wpc_pkg::*;
(
    input  logic       own_i,
    input  logic       link_i,
    input  logic [1:0] mode_i,
    output logic       res_o
);

    always_comb begin
        case (chain_e'(mode_i))
            CH_SOLO: res_o = own_i;
            CH_AND:  res_o = own_i & link_i;
            CH_OR:   res_o = own_i | link_i;
            default: res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wpc_counter.sv
`timescale 1ns/1ps
module wpc_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [2*CNT_W-1:0] wr_data_i,
    input  logic [INC_W-1:0]   inc_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   match_o,
    output logic               eq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mat;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.cnt = wr_data_i[CNT_W-1:0];
            st_d.mat = wr_data_i[2*CNT_W-1:CNT_W];
        end else begin
            st_d.cnt = st_q.cnt + {{(CNT_W-INC_W){1'b0}}, inc_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign match_o = st_q.mat;
    assign eq_o    = (st_q.cnt == st_q.mat);

endmodule

// File: rtl/wp_chain_unit.sv
`timescale 1ns/1ps
module wp_chain_unit
    import wpc_pkg::*;
#(
    parameter int NUM_CMP = 8,
    parameter int CNT_W   = 16,
    parameter int REG_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_i,
    input  logic [NUM_CMP-1:0]   hit_i,
    input  logic                 ext_hit_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_addr_i,
    input  logic [REG_W-1:0]     cfg_wdata_i,
    output logic [REG_W-1:0]     cfg_rdata_o,
    output logic [NUM_CMP+2:0]   wp_o,
    output logic                 brk_o
);

    localparam int NWP   = NUM_CMP + 3;
    localparam int INC_W = $clog2(NWP + 1);

    typedef struct packed {
        logic [2*NWP-1:0] mode;
        logic [NWP-1:0]   asg;
        logic [NWP-1:0]   bg;
        logic [1:0]       en;
        logic [NWP-1:0]   wp;
        logic             brk;
    } st_t;

    st_t s_d, s_q;

    logic [NWP-1:0]   own;
    logic [NWP-1:0]   wp_new;
    logic [NWP-1:0]   rise;
    logic [1:0]       cnt_eq;
    logic [CNT_W-1:0] cnt_cur [2];
    logic [CNT_W-1:0] mat_cur [2];
    logic [INC_W-1:0] inc     [2];

    assign own  = {ext_hit_i, cnt_eq[1], cnt_eq[0], hit_i};
    assign rise = wp_new & ~s_q.wp;

    // Cascaded chain: each cell links to the fresh result of the one below.
    for (genvar i = 0; i < NWP; i++) begin : g_cell
        logic link;
        if (i == 0) begin : g_base
            assign link = own[0];
        end else begin : g_up
            assign link = wp_new[i-1];
        end
        wpc_cell u_cell (
            .own_i  (own[i]),
            .link_i (link),
            .mode_i (s_q.mode[2*i +: 2]),
            .res_o  (wp_new[i])
        );
    end

    always_comb begin
        inc[0] = '0;
        inc[1] = '0;
        if (eval_i) begin
            if (s_q.en[0]) inc[0] = INC_W'($countones(rise & ~s_q.asg));
            if (s_q.en[1]) inc[1] = INC_W'($countones(rise &  s_q.asg));
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        wpc_counter #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (cfg_we_i && (cfg_addr_i == ADDR_CNT0 + 2'(k))),
            .wr_data_i (cfg_wdata_i[2*CNT_W-1:0]),
            .inc_i     (inc[k]),
            .cnt_o     (cnt_cur[k]),
            .match_o   (mat_cur[k]),
            .eq_o      (cnt_eq[k])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.brk = 1'b0;
        if (eval_i) begin
            s_d.wp  = wp_new;
            s_d.brk = |(rise & s_q.bg);
        end
        if (cfg_we_i) begin
            case (cfg_addr_i)
                ADDR_MODE: s_d.mode = cfg_wdata_i[2*NWP-1:0];
                ADDR_CTRL: begin
                    s_d.asg = cfg_wdata_i[NWP-1:0];
                    s_d.bg  = cfg_wdata_i[2*NWP-1:NWP];
                    s_d.en  = cfg_wdata_i[2*NWP+1:2*NWP];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_addr_i)
            ADDR_MODE: cfg_rdata_o[2*NWP-1:0] = s_q.mode;
            ADDR_CTRL: cfg_rdata_o[2*NWP+1:0] = {s_q.en, s_q.bg, s_q.asg};
            ADDR_CNT0: cfg_rdata_o[2*CNT_W-1:0] = {mat_cur[0], cnt_cur[0]};
            default:   cfg_rdata_o[2*CNT_W-1:0] = {mat_cur[1], cnt_cur[1]};
        endcase
    end

    assign wp_o  = s_q.wp;
    assign brk_o = s_q.brk;

endmodule

// File: rtl/wpc_checker.sv
`timescale 1ns/1ps
module wpc_checker #(
    parameter int NWP   = 11,
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval_i,
    input logic             hit0,
    input logic [1:0]       mode0,
    input logic             we,
    input logic [1:0]       addr,
    input logic [REG_W-1:0] wdata,
    input logic [NWP-1:0]   wp,
    input logic             brk,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1
);

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(wp)); // R6

    AST_BRK_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> $past(eval_i)); // R8

    AST_BRK_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> ((wp & ~$past(wp)) != '0)); // R8

    AST_WP0_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && mode0 == 2'd0) |=> (wp[0] == $past(hit0))); // R3

    AST_CNT0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd2) |=> (cnt0 == $past(wdata[CNT_W-1:0]))); // R9

    AST_CNT1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_i && !we) |=> $stable(cnt1)); // R7

endmodule

bind wp_chain_unit wpc_checker #(
    .NWP   (NUM_CMP + 3),
    .CNT_W (CNT_W),
    .REG_W (REG_W)
) u_wpc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval_i (eval_i),
    .hit0   (hit_i[0]),
    .mode0  (s_q.mode[1:0]),
    .we     (cfg_we_i),
    .addr   (cfg_addr_i),
    .wdata  (cfg_wdata_i),
    .wp     (wp_o),
    .brk    (brk_o),
    .cnt0   (cnt_cur[0]),
    .cnt1   (cnt_cur[1])
);

// File: tb/test_wp_chain_unit.sv
`timescale 1ns/1ps
module test_wp_chain_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [7:0]  hit_i = '0;
    logic        ext_hit_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic [10:0] wp_o;
    logic        brk_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wp_chain_unit i_wp_chain_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_i      (eval_i),
        .hit_i       (hit_i),
        .ext_hit_i   (ext_hit_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .wp_o        (wp_o),
        .brk_o       (brk_o)
    );

    // Reference state built from the requirements.
    logic [21:0] m_mode = '0;
    logic [10:0] m_asg  = '0;
    logic [10:0] m_bg   = '0;
    logic [1:0]  m_en   = '0;
    logic [15:0] m_cnt [2];
    logic [15:0] m_mat [2];
    logic [10:0] m_wp   = '0;
    logic        m_brk  = 1'b0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [1:0] a);
        logic [31:0] v = '0;
        case (a)
            2'd0: v[21:0] = m_mode;
            2'd1: v[23:0] = {m_en, m_bg, m_asg};
            2'd2: v = {m_mat[0], m_cnt[0]};
            default: v = {m_mat[1], m_cnt[1]};
        endcase
        return v;
    endfunction

    task automatic model_step(input logic ev, input logic [7:0] h, input logic x,
                              input logic we, input logic [1:0] a, input logic [31:0] wd);
        logic [10:0] own, nw, rise;
        logic        prev;
        own = {x, (m_cnt[1] == m_mat[1]), (m_cnt[0] == m_mat[0]), h};
        for (int i = 0; i < 11; i++) begin
            prev = (i == 0) ? own[0] : nw[i-1];
            case (m_mode[2*i +: 2])
                2'd0: nw[i] = own[i];
                2'd1: nw[i] = own[i] & prev;
                2'd2: nw[i] = own[i] | prev;
                default: nw[i] = 1'b0;
            endcase
        end
        rise  = nw & ~m_wp;
        m_brk = ev && ((rise & m_bg) != '0);
        if (ev) begin
            for (int i = 0; i < 11; i++) begin
                if (rise[i]) begin
                    if (m_asg[i] && m_en[1]) m_cnt[1] = m_cnt[1] + 16'd1;
                    if (!m_asg[i] && m_en[0]) m_cnt[0] = m_cnt[0] + 16'd1;
                end
            end
            m_wp = nw;
        end
        if (we) begin
            case (a)
                2'd0: m_mode = wd[21:0];
                2'd1: begin m_asg = wd[10:0]; m_bg = wd[21:11]; m_en = wd[23:22]; end
                2'd2: begin m_cnt[0] = wd[15:0]; m_mat[0] = wd[31:16]; end
                default: begin m_cnt[1] = wd[15:0]; m_mat[1] = wd[31:16]; end
            endcase
        end
    endtask

    task automatic cyc(input logic ev, input logic [7:0] h, input logic x,
                       input logic we, input logic [1:0] a, input logic [31:0] wd,
                       input string tag);
        @(negedge clk);
        eval_i = ev; hit_i = h; ext_hit_i = x;
        cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = wd;
        model_step(ev, h, x, we, a, wd);
        @(posedge clk);
        #1;
        chk({21'd0, wp_o}, {21'd0, m_wp}, {tag, " wp"});
        chk({31'd0, brk_o}, {31'd0, m_brk}, {tag, " brk"});
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] wd);
        cyc(1'b0, hit_i, ext_hit_i, 1'b1, a, wd, "R10 write");
    endtask

    task automatic ev(input logic [7:0] h, input logic x, input string tag);
        cyc(1'b1, h, x, 1'b0, 2'd0, 32'd0, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        @(negedge clk);
        eval_i = 1'b0; cfg_we_i = 1'b0; cfg_addr_i = a;
        #1;
        chk(cfg_rdata_o, model_rd(a), tag);
        model_step(1'b0, hit_i, ext_hit_i, 1'b0, a, 32'd0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_cnt[0] = '0; m_cnt[1] = '0; m_mat[0] = '0; m_mat[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk({21'd0, wp_o}, 32'd0, "R1 reset wp");
        chk({31'd0, brk_o}, 32'd0, "R1 reset brk");
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset reg");

        // R3: watchpoint 0 in modes 0,1,2 follows hit 0; counters equal so wp8 is true (R5).
        ev(8'h01, 1'b0, "R3 solo");
        ev(8'h00, 1'b0, "R3 solo low");
        wr(2'd0, 32'h1);
        ev(8'h01, 1'b0, "R3 and-mode");
        wr(2'd0, 32'h2);
        ev(8'h00, 1'b0, "R3 or-mode");

        // R2: wp1 AND, wp2 OR, wp3 off.
        wr(2'd0, {22'd0, 2'd3, 2'd2, 2'd1, 2'd0} );
        ev(8'h0E, 1'b0, "R2 and-broken");
        ev(8'h03, 1'b0, "R2 and-ok or-chained");
        ev(8'h0F, 1'b0, "R2 off");

        // R4: full AND cascade through 1..10, a broken middle link.
        wr(2'd0, 32'h0015_5554);
        ev(8'hFF, 1'b1, "R4 full cascade");
        ev(8'hF7, 1'b1, "R4 broken link");
        wr(2'd0, 32'h002A_AAA8);
        ev(8'h01, 1'b0, "R4 or cascade");

        // R5/R7/R8: counters, match, external hit, breakpoints.
        wr(2'd0, 32'h0);
        wr(2'd2, {16'd2, 16'd0});
        wr(2'd3, {16'd5, 16'd5});
        wr(2'd1, {8'd0, 2'b11, 11'h7FF, 11'h0F0});
        ev(8'h00, 1'b0, "R5 clear");
        ev(8'hFF, 1'b0, "R7 multi rise");
        rd(2'd2, "R7 counter0");
        rd(2'd3, "R7 counter1");
        ev(8'hFF, 1'b0, "R8 held true no brk");
        ev(8'h00, 1'b1, "R5 ext hit");
        ev(8'h00, 1'b1, "R5 counter eq");
        rd(2'd2, "R7 counter0 after");

        // R6: no strobe, inputs change.
        cyc(1'b0, 8'hA5, 1'b0, 1'b0, 2'd0, 32'd0, "R6 hold");
        cyc(1'b0, 8'h5A, 1'b1, 1'b0, 2'd0, 32'd0, "R6 hold");

        // R7 wrap.
        wr(2'd2, {16'd9, 16'hFFFF});
        ev(8'h00, 1'b0, "R7 prep");
        ev(8'h01, 1'b0, "R7 wrap");
        rd(2'd2, "R7 wrap value");

        // R9: write collides with increment.
        ev(8'h00, 1'b0, "R9 prep");
        cyc(1'b1, 8'h0F, 1'b0, 1'b1, 2'd2, {16'd7, 16'd100}, "R9 collide");
        rd(2'd2, "R9 write wins");

        // Random mix (R2/R7/R8/R10).
        for (int n = 0; n < 3000; n++) begin
            r = $urandom();
            if (n == 0) void'($urandom(32'h5eed));
            case (r[3:0])
                4'd0: wr(2'd0, $urandom());
                4'd1: wr(2'd1, $urandom());
                4'd2: wr(2'd2, {14'd0, r[9:8], 14'd0, r[11:10]});
                4'd3: wr(2'd3, {14'd0, r[13:12], 14'd0, r[15:14]});
                4'd4: rd(r[5:4], "R10 random read");
                4'd5: cyc(1'b0, r[23:16], r[24], 1'b0, 2'd0, 32'd0, "R6 random idle");
                default: ev(r[23:16], r[24], "R2/R7/R8 random");
            endcase
        end
        for (int a = 0; a < 4; a++) rd(2'(a), "R10 final read");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule